// File: doc/BRIEF.md
# System Clock Source Switcher

This block picks which of up to eight oscillator sources drives the system clock and divides that clock down with a post-divider that can ramp gradually. Software reaches it through a small register port. The port has a control register, a slew register and a key register. A write to either protected register takes effect only after a two-word key sequence.

To change source, software writes a requested-source code with the switch-start bit set. One cycle later the block checks that source's ready input. If the source is not ready, the request is dropped, the start bit clears, and the current source stays as it was. If the source is ready, a fixed settling delay runs. At its end the current-source field and the one-hot select output move to the new source, and the start bit clears.

The post-divider target is written into the slew register. Each direction of change has its own enable. When a direction is enabled, the effective divider code walks toward the target one step per programmable interval. When a direction is disabled, the code jumps straight to the target. A busy flag is set while the effective code differs from the target. The analog glitch-free mux itself is not modelled: a change of the select output stands for it.

Top module: `sysclk_switch`

## Requirements
- R1: After reset the current and requested source codes are 0, `src_sel` is 8'h01, the switch-start bit and busy are 0, `div_code` is 0, and `sys_clk_en` is high on every cycle.
- R2: Writes to address 0 (control) and address 1 (slew) are ignored unless the two writes just before them on the port were key A and then key B to address 2. One unlock admits exactly one protected write. Any other write between the two keys cancels the sequence.
- R3: The control register read layout is: bit 0 switch-start, bits 10:8 requested source, bits 14:12 current source. All other bits read 0.
- R4: An accepted switch (ready input of the requested source high one edge after the write) updates the current-source field and `src_sel` on the fifth rising edge after the write edge. The switch-start bit clears on that same edge and reads 1 until then.
- R5: A rejected switch (ready input low at that check) clears the switch-start bit on the first edge after the write. The current source and `src_sel` are left unchanged.
- R6: A control write arriving while the switch-start bit is 1 is ignored, including its requested-source field.
- R7: `src_sel` is one-hot, with bit n set when the current source is n.
- R8: The slew register read layout is: bit 0 busy (read-only), bit 1 enable for ramping the divider code upward, bit 2 enable for ramping it downward, bits 10:8 step interval S, bits 23:20 target divider code. All other bits read 0.
- R9: When the ramp for the needed direction is enabled, `div_code` moves by one every S+1 edges. The first move comes S+1 edges after the write edge.
- R10: When the ramp for the needed direction is disabled, `div_code` equals the target one edge after the write.
- R11: Busy reads 1 from the write edge until `div_code` equals the target, and 0 afterwards.
- R12: `sys_clk_en` pulses once every `div_code`+1 cycles, dividing by the code plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 slew, 2 key |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational |
| src_ready | input | 8 | Per-source ready flags |
| src_sel | output | 8 | One-hot current source select |
| div_code | output | 4 | Effective post-divider code |
| sys_clk_en | output | 1 | Divided system clock enable pulse |

## Verification
The hardest states to reach are a control write landing in the middle of an accepted switch, and a write that follows a broken or already-used unlock. Both depend on several port writes arriving in exact cycle order. The stimulus issues writes back to back, one per cycle. In the first case it fires the key pair and a second control write within the four-cycle settling window, then confirms the first request still completes untouched. The divider ramp is sampled on the exact edges where each step lands, in both directions and at two step intervals.

// File: rtl/sysclk_sw_pkg.sv
package sysclk_sw_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_SLEW = 2'd1;
    localparam logic [1:0] ADDR_KEY  = 2'd2;

    localparam logic [31:0] KEY_FIRST  = 32'hAA99_6655;
    localparam logic [31:0] KEY_SECOND = 32'h5566_99AA;

    // control register field positions
    localparam int GO_BIT  = 0;
    localparam int REQ_LSB = 8;
    localparam int CUR_LSB = 12;
    localparam int CODE_W  = 3;

    // slew register field positions
    localparam int BUSY_BIT = 0;
    localparam int RUP_BIT  = 1;
    localparam int RDN_BIT  = 2;
    localparam int STEP_LSB = 8;
    localparam int TGT_LSB  = 20;

    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_CHECK = 2'd1,
        SW_RUN   = 2'd2
    } sw_phase_t;
endpackage

// File: rtl/sysclk_unlock.sv
// Key-sequence gate for protected register writes.
// Assumes: key A then key B, as consecutive writes to the key address,
// arm exactly one following write to the control or slew address.
module sysclk_unlock
    import sysclk_sw_pkg::*;
#(
    parameter logic [31:0] KEY_A = KEY_FIRST,
    parameter logic [31:0] KEY_B = KEY_SECOND
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic        prot_ok
);
    logic half_key;
    logic open_q;
    logic prot_addr;

    assign prot_addr = (wr_addr == ADDR_CTRL) || (wr_addr == ADDR_SLEW);
    assign prot_ok   = wr_en && prot_addr && open_q;

    // track the key sequence and consume the unlock on a protected write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_key <= 1'b0;
            open_q   <= 1'b0;
        end else if (wr_en) begin
            half_key <= (wr_addr == ADDR_KEY) && (wr_data == KEY_A);
            if (wr_addr == ADDR_KEY) begin
                if (half_key && (wr_data == KEY_B))
                    open_q <= 1'b1;
            end else if (prot_addr) begin
                open_q <= 1'b0;
            end
        end
    end

    // R2: the gate opens only right after a key B write that followed key A
    p_open_after_keys_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_q) |-> $past(wr_en && wr_addr == ADDR_KEY && wr_data == KEY_B));
endmodule

// File: rtl/sysclk_src_switch.sv
// Source switch sequencer: checks the requested source's ready flag one
// cycle after a start request, then waits SW_LAT cycles before committing.
// Assumes: NSRC <= 8, source codes are 3 bits, codes >= NSRC are never ready.
module sysclk_src_switch
    import sysclk_sw_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int SW_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CODE_W-1:0] req_in,
    input  logic              go_in,
    input  logic [NSRC-1:0]   src_ready,
    output logic [CODE_W-1:0] cur_o,
    output logic [CODE_W-1:0] req_o,
    output logic              go_o,
    output logic [NSRC-1:0]   src_sel
);
    localparam int CNT_W = (SW_LAT > 1) ? $clog2(SW_LAT) : 1;

    sw_phase_t         phase;
    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] cur_q;
    logic [CODE_W-1:0] req_q;
    logic              go_q;
    logic [7:0]        rdy_pad;

    // widen the ready vector so every 3-bit code indexes a defined bit
    always_comb begin
        rdy_pad = '0;
        rdy_pad[NSRC-1:0] = src_ready;
    end

    // switch sequence: accept request, check readiness, settle, commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= SW_IDLE;
            cnt   <= '0;
            cur_q <= '0;
            req_q <= '0;
            go_q  <= 1'b0;
        end else begin
            case (phase)
                SW_IDLE: begin
                    if (ctrl_wr) begin
                        req_q <= req_in;
                        if (go_in) begin
                            go_q  <= 1'b1;
                            phase <= SW_CHECK;
                        end
                    end
                end
                SW_CHECK: begin
                    if (rdy_pad[req_q]) begin
                        cnt   <= '0;
                        phase <= SW_RUN;
                    end else begin
                        go_q  <= 1'b0;
                        phase <= SW_IDLE;
                    end
                end
                SW_RUN: begin
                    if (cnt == CNT_W'(SW_LAT - 1)) begin
                        cur_q <= req_q;
                        go_q  <= 1'b0;
                        phase <= SW_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= SW_IDLE;
            endcase
        end
    end

    // one-hot decode of the committed source
    for (genvar g = 0; g < NSRC; g++) begin : g_sel
        assign src_sel[g] = (cur_q == CODE_W'(g));
    end

    assign cur_o = cur_q;
    assign req_o = req_q;
    assign go_o  = go_q;

    // R4: the committed source moves only as a running switch ends
    p_cur_on_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q) |-> ($past(go_q) && !go_q));
    // R4: the start bit rises only from a control write that asked for it
    p_go_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_q) |-> $past(ctrl_wr && go_in));
    // R5: a failed readiness check drops the request without a source change
    p_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase == SW_CHECK) && !$past(rdy_pad[req_q])) |-> (!go_q && $stable(cur_q)));
    // R6: control writes during a pending switch leave the request alone
    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go_q && ctrl_wr) |=> $stable(req_q));
endmodule

// File: rtl/sysclk_slew_div.sv
// Post-divider with direction-dependent ramp and an enable-pulse generator.
// Assumes: the divide ratio is code+1; the step interval is step+1 cycles.
module sysclk_slew_div #(
    parameter int DIV_W  = 4,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slew_wr,
    input  logic [DIV_W-1:0]  tgt_in,
    input  logic [STEP_W-1:0] step_in,
    input  logic              rup_in,
    input  logic              rdn_in,
    output logic [DIV_W-1:0]  eff_o,
    output logic [DIV_W-1:0]  tgt_o,
    output logic [STEP_W-1:0] step_o,
    output logic              rup_o,
    output logic              rdn_o,
    output logic              busy_o,
    output logic              clk_en_o
);
    logic [DIV_W-1:0]  eff_q;
    logic [DIV_W-1:0]  tgt_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] tick_q;
    logic              rup_q;
    logic              rdn_q;
    logic              rising;
    logic              dir_en;
    logic [DIV_W-1:0]  pdiv_q;

    assign rising = (tgt_q > eff_q);
    assign dir_en = rising ? rup_q : rdn_q;
    assign busy_o = (eff_q != tgt_q);

    // capture settings and walk or jump the effective code toward the target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_q  <= '0;
            tgt_q  <= '0;
            step_q <= '0;
            tick_q <= '0;
            rup_q  <= 1'b0;
            rdn_q  <= 1'b0;
        end else if (slew_wr) begin
            tgt_q  <= tgt_in;
            step_q <= step_in;
            rup_q  <= rup_in;
            rdn_q  <= rdn_in;
            tick_q <= '0;
        end else if (eff_q != tgt_q) begin
            if (!dir_en) begin
                eff_q <= tgt_q;
            end else if (tick_q == step_q) begin
                eff_q  <= rising ? eff_q + 1'b1 : eff_q - 1'b1;
                tick_q <= '0;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    // divide-by-(code+1) enable pulse counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            pdiv_q <= '0;
        else if (pdiv_q >= eff_q)
            pdiv_q <= '0;
        else
            pdiv_q <= pdiv_q + 1'b1;
    end

    assign clk_en_o = (pdiv_q >= eff_q);
    assign eff_o    = eff_q;
    assign tgt_o    = tgt_q;
    assign step_o   = step_q;
    assign rup_o    = rup_q;
    assign rdn_o    = rdn_q;

    // R9: with the ramp enabled the code never moves by more than one
    p_step_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(slew_wr) && $past(dir_en) && $past(eff_q != tgt_q)) |->
        (eff_q == $past(eff_q) || eff_q == $past(eff_q) + DIV_W'(1) ||
         eff_q == $past(eff_q) - DIV_W'(1)));
    // R10: with the ramp disabled the code lands on the target in one edge
    p_jump_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(slew_wr) && !$past(dir_en) && $past(eff_q != tgt_q)) |->
        (eff_q == $past(tgt_q)));
    // R11: busy can only appear because a new target was written
    p_busy_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(slew_wr));
endmodule

// File: rtl/sysclk_switch.sv
// System clock source switcher top: register decode, key gate, source
// sequencer and slewed post-divider.
// Assumes: single-cycle write strobe; reads are combinational.
module sysclk_switch
    import sysclk_sw_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int SW_LAT = 4,
    parameter int DIV_W  = 4,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic [NSRC-1:0]   src_ready,
    output logic [NSRC-1:0]   src_sel,
    output logic [DIV_W-1:0]  div_code,
    output logic              sys_clk_en
);
    logic              prot_ok;
    logic              ctrl_wr;
    logic              slew_wr;
    logic [CODE_W-1:0] cur_code;
    logic [CODE_W-1:0] req_code;
    logic              go_bit;
    logic [DIV_W-1:0]  tgt_code;
    logic [STEP_W-1:0] step_val;
    logic              rup_en;
    logic              rdn_en;
    logic              busy;

    assign ctrl_wr = prot_ok && (wr_addr == ADDR_CTRL);
    assign slew_wr = prot_ok && (wr_addr == ADDR_SLEW);

    sysclk_unlock u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .prot_ok (prot_ok)
    );

    sysclk_src_switch #(.NSRC(NSRC), .SW_LAT(SW_LAT)) u_switch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .req_in    (wr_data[REQ_LSB +: CODE_W]),
        .go_in     (wr_data[GO_BIT]),
        .src_ready (src_ready),
        .cur_o     (cur_code),
        .req_o     (req_code),
        .go_o      (go_bit),
        .src_sel   (src_sel)
    );

    sysclk_slew_div #(.DIV_W(DIV_W), .STEP_W(STEP_W)) u_slew (
        .clk      (clk),
        .rst_n    (rst_n),
        .slew_wr  (slew_wr),
        .tgt_in   (wr_data[TGT_LSB +: DIV_W]),
        .step_in  (wr_data[STEP_LSB +: STEP_W]),
        .rup_in   (wr_data[RUP_BIT]),
        .rdn_in   (wr_data[RDN_BIT]),
        .eff_o    (div_code),
        .tgt_o    (tgt_code),
        .step_o   (step_val),
        .rup_o    (rup_en),
        .rdn_o    (rdn_en),
        .busy_o   (busy),
        .clk_en_o (sys_clk_en)
    );

    // assemble the read word for the addressed register
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL: begin
                rd_data[GO_BIT]                = go_bit;
                rd_data[REQ_LSB +: CODE_W]     = req_code;
                rd_data[CUR_LSB +: CODE_W]     = cur_code;
            end
            ADDR_SLEW: begin
                rd_data[BUSY_BIT]              = busy;
                rd_data[RUP_BIT]               = rup_en;
                rd_data[RDN_BIT]               = rdn_en;
                rd_data[STEP_LSB +: STEP_W]    = step_val;
                rd_data[TGT_LSB +: DIV_W]      = tgt_code;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: tb/sysclk_switch_tb.sv
module sysclk_switch_tb;
    import sysclk_sw_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;
    logic [7:0]  src_ready;
    logic [7:0]  src_sel;
    logic [3:0]  div_code;
    logic        sys_clk_en;

    int n_chk = 0;
    int n_fail = 0;

    sysclk_switch u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_ready(src_ready), .src_sel(src_sel), .div_code(div_code),
        .sys_clk_en(sys_clk_en)
    );

    always #2 clk = ~clk;

    // vectors: [11:9] requested code, [8:1] ready mask, [0] accept expected
    localparam logic [11:0] VEC [6] = '{
        {3'd2, 8'h04, 1'b1},
        {3'd5, 8'hDF, 1'b0},
        {3'd7, 8'h80, 1'b1},
        {3'd0, 8'hFE, 1'b0},
        {3'd1, 8'hFF, 1'b1},
        {3'd0, 8'h01, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // caller is at a falling edge; write lands on the next rising edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic unlock();
        wr(ADDR_KEY, KEY_FIRST);
        wr(ADDR_KEY, KEY_SECOND);
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [2:0]  exp_cur;
        logic [2:0]  exp_req;
        int          pulses;

        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; src_ready = 8'h01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(ADDR_CTRL, v); check("R1 ctrl", v, 32'h0);
        rd(ADDR_SLEW, v); check("R1 slew", v, 32'h0);
        check("R1 sel", 32'(src_sel), 32'h01);
        check("R1 div", 32'(div_code), 32'h0);
        check("R1 clk_en", 32'(sys_clk_en), 32'h1);
        @(negedge clk);
        check("R1 clk_en 2", 32'(sys_clk_en), 32'h1);

        exp_cur = 3'd0;
        exp_req = 3'd0;
        for (int i = 0; i < 6; i++) begin
            logic [2:0] rq;
            rq = VEC[i][11:9];
            src_ready = VEC[i][8:1];
            unlock();
            wr(ADDR_CTRL, (32'(rq) << 8) | 32'h1);
            exp_req = rq;
            if (VEC[i][0]) begin
                repeat (4) @(negedge clk);
                rd(ADDR_CTRL, v);
                check("R4 cur held during settle", 32'(v[14:12]), 32'(exp_cur));
                check("R4 start bit held", 32'(v[0]), 32'h1);
                @(negedge clk);
                rd(ADDR_CTRL, v);
                exp_cur = rq;
                check("R4 cur committed", 32'(v[14:12]), 32'(exp_cur));
                check("R4 start bit cleared", 32'(v[0]), 32'h0);
                check("R7 one-hot select", 32'(src_sel), 32'h1 << exp_cur);
            end else begin
                @(negedge clk);
                rd(ADDR_CTRL, v);
                check("R5 start bit cleared", 32'(v[0]), 32'h0);
                check("R5 cur unchanged", 32'(v[14:12]), 32'(exp_cur));
                check("R5 select unchanged", 32'(src_sel), 32'h1 << exp_cur);
            end
            check("R3 request field", 32'(v[10:8]), 32'(rq));
            check("R3 unused bits", v & ~32'h7701, 32'h0);
        end

        // R2 locked write is ignored
        src_ready = 8'hFF;
        @(negedge clk);
        wr(ADDR_CTRL, (32'd5 << 8) | 32'h1);
        repeat (6) @(negedge clk);
        rd(ADDR_CTRL, v);
        check("R2 locked write ignored", v, (32'(exp_cur) << 12) | (32'(exp_req) << 8));

        // R2 one unlock admits one write
        @(negedge clk);
        unlock();
        wr(ADDR_CTRL, 32'd3 << 8);
        wr(ADDR_CTRL, 32'd6 << 8);
        rd(ADDR_CTRL, v);
        check("R2 single write per unlock", 32'(v[10:8]), 32'd3);

        // R2 interrupted key sequence does not unlock
        @(negedge clk);
        wr(ADDR_KEY, KEY_FIRST);
        wr(ADDR_CTRL, 32'd4 << 8);
        wr(ADDR_KEY, KEY_SECOND);
        wr(ADDR_CTRL, 32'd4 << 8);
        rd(ADDR_CTRL, v);
        check("R2 broken sequence", 32'(v[10:8]), 32'd3);

        // R6 control write during a pending switch is ignored
        @(negedge clk);
        unlock();
        wr(ADDR_CTRL, (32'd3 << 8) | 32'h1);
        unlock();
        wr(ADDR_CTRL, (32'd6 << 8) | 32'h1);
        repeat (2) @(negedge clk);
        rd(ADDR_CTRL, v);
        check("R6 request kept", 32'(v[10:8]), 32'd3);
        check("R6 switch completed", 32'(v[14:12]), 32'd3);
        check("R6 start cleared", 32'(v[0]), 32'h0);
        check("R7 select after R6", 32'(src_sel), 32'h08);

        // R9 R11 upward ramp, interval 2, target 3
        @(negedge clk);
        unlock();
        wr(ADDR_SLEW, (32'd3 << 20) | (32'd1 << 8) | 32'h2);
        rd(ADDR_SLEW, v);
        check("R11 busy set", 32'(v[0]), 32'h1);
        check("R8 slew fields", v & ~32'h1, (32'd3 << 20) | (32'd1 << 8) | 32'h2);
        @(negedge clk);
        check("R9 no step yet", 32'(div_code), 32'd0);
        @(negedge clk);
        check("R9 first step", 32'(div_code), 32'd1);
        repeat (2) @(negedge clk);
        check("R9 second step", 32'(div_code), 32'd2);
        repeat (2) @(negedge clk);
        check("R9 reached target", 32'(div_code), 32'd3);
        rd(ADDR_SLEW, v);
        check("R11 busy cleared", 32'(v[0]), 32'h0);

        // R12 divide by four
        pulses = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (sys_clk_en) pulses++;
        end
        check("R12 pulse count div4", 32'(pulses), 32'd10);

        // R10 downward jump with downward ramp disabled
        unlock();
        wr(ADDR_SLEW, (32'd0 << 20) | (32'd1 << 8) | 32'h2);
        rd(ADDR_SLEW, v);
        check("R11 busy on jump", 32'(v[0]), 32'h1);
        check("R10 before jump", 32'(div_code), 32'd3);
        @(negedge clk);
        check("R10 jump landed", 32'(div_code), 32'd0);
        rd(ADDR_SLEW, v);
        check("R11 busy after jump", 32'(v[0]), 32'h0);

        // R10 upward jump, then R9 downward ramp at interval 1
        @(negedge clk);
        unlock();
        wr(ADDR_SLEW, 32'd5 << 20);
        @(negedge clk);
        check("R10 upward jump", 32'(div_code), 32'd5);
        unlock();
        wr(ADDR_SLEW, (32'd2 << 20) | 32'h4);
        @(negedge clk);
        check("R9 down step 1", 32'(div_code), 32'd4);
        repeat (2) @(negedge clk);
        check("R9 down reached", 32'(div_code), 32'd2);
        rd(ADDR_SLEW, v);
        check("R11 busy after ramp down", 32'(v[0]), 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule